// File: doc/BRIEF.md
# Display Raster Timing Generator

This block generates the scan timing for one display pipe. A horizontal counter steps once per pixel clock and a vertical counter steps once per line. From those two counters the block derives a data-enable, horizontal and vertical blanking, horizontal and vertical sync, a flag for pixels that fall inside the source image, and the current pixel coordinates. Every output is registered, so all of them line up in the same cycle.

Software sets up the pipe through a simple word-wide register port. Each timing window is one word that holds two counts, and each count is stored minus one. Software first writes the six timing words and the source size while the pipe is stopped. It then sets the run-request bit and polls the running-status bit. Scanning always starts at pixel (0,0). When the request is cleared, the current frame is finished before the pipe stops. The block ignores any write to a timing word while the pipe is requested or running, and it records each such attempt in a sticky error bit.

Top module: `dtg_top`

## Requirements
- R1: The register port has word addresses 1 = horizontal total, 2 = horizontal blank, 3 = horizontal sync, 4 = vertical total, 5 = vertical blank, 6 = vertical sync and 7 = source size. Each timing word holds a start value minus one in bits 15:0 and an end value minus one in bits 31:16. For the total words, start means active and end means total. In the source word, bits 15:0 hold the vertical active minus one and bits 31:16 hold the horizontal active minus one. A word written while the pipe is stopped reads back unchanged.
- R2: While the pipe is running, pix_x_o counts from 0 up to the horizontal total minus one and then wraps to 0. pix_y_o advances by one at each horizontal wrap and returns to 0 after the vertical total minus one.
- R3: hblank_o (vblank_o) is high when the count is greater than the low half of the blank word and no greater than its high half.
- R4: hsync_o (vsync_o) is high when the count is greater than the low half of the sync word and no greater than its high half. This gives a pulse that starts at active plus front porch and lasts for the pulse width. Sync is active high by default.
- R5: de_o is high when both counts are at or below the low half of their total words.
- R6: src_hit_o is high when pix_x_o is at or below bits 31:16 of the source word and pix_y_o is at or below bits 15:0 of the source word.
- R7: Address 0 is the control word. Bit 31 is the run request and can be read and written. Bit 30 is the running status and is read-only. The status rises one cycle after the request is written, with both counters at 0.
- R8: After the request is cleared, scanning continues to the last pixel of the current frame. The status then falls.
- R9: A write to addresses 1 to 7 while bit 31 or bit 30 is set leaves the word unchanged and sets bit 29 of the control word. Bit 29 stays set until the control word is written with bit 29 = 1.
- R10: The outputs appear one cycle after the counter state that produces them. While the pipe is stopped, the counters hold at 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| de_o | output | 1 | Active-video data enable |
| src_hit_o | output | 1 | Pixel lies inside the source image |
| pix_x_o | output | 16 | Horizontal pixel coordinate |
| pix_y_o | output | 16 | Vertical pixel coordinate |

## Verification
A request written at clock edge E0 makes the status readable after E1. At that point the counters sit at (0,0), and the outputs for pixel k appear after edge E2+k. The bench reads the status after E0 and again after E1. It then pushes one expected item per pixel into a queue and starts a monitor that pops one item on every falling edge, starting with the edge after E2. After the last pixel of the final frame, the queue holds idle items that expect all outputs low. Blocked writes and the clearing of the request happen in the middle of a frame, so the expected stream must still pass unchanged around them.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int REG_AW  = 3;
    localparam int NUM_TIM = (1 << REG_AW) - 1;
    localparam int NUM_AX  = 2;

    localparam int BIT_REQ = WORD_W - 1;
    localparam int BIT_RUN = WORD_W - 2;
    localparam int BIT_ERR = WORD_W - 3;

    typedef logic [HALF_W-1:0] cnt_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL = 3'd0,
        A_HTOT = 3'd1,
        A_HBLK = 3'd2,
        A_HSYN = 3'd3,
        A_VTOT = 3'd4,
        A_VBLK = 3'd5,
        A_VSYN = 3'd6,
        A_SRC  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        cnt_t act_m1;
        cnt_t tot_m1;
        cnt_t blk_s_m1;
        cnt_t blk_e_m1;
        cnt_t syn_s_m1;
        cnt_t syn_e_m1;
        cnt_t src_m1;
    } axis_cfg_t;

    typedef struct packed {
        logic act;
        logic blank;
        logic sync;
        logic src;
    } axis_flags_t;

    function automatic cnt_t lo_half(word_t w);
        return w[HALF_W-1:0];
    endfunction

    function automatic cnt_t hi_half(word_t w);
        return w[WORD_W-1:HALF_W];
    endfunction

    function automatic logic in_span(cnt_t c, cnt_t s_m1, cnt_t e_m1);
        return (c > s_m1) && (c <= e_m1);
    endfunction

endpackage

// File: rtl/dtg_regfile.sv
module dtg_regfile
    import dtg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    wr_addr,
    input  word_t                wr_data,
    input  logic [REG_AW-1:0]    rd_addr,
    output word_t                rd_data,
    input  logic                 run_i,
    output logic                 req_o,
    output axis_cfg_t            hcfg_o,
    output axis_cfg_t            vcfg_o
);

    word_t tim_q [NUM_TIM];
    logic  req_q;
    logic  err_q;
    logic  locked;
    logic  tim_wr;

    assign locked = req_q | run_i;
    assign tim_wr = wr_en && (wr_addr != A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            err_q <= 1'b0;
            for (int i = 0; i < NUM_TIM; i++) tim_q[i] <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                req_q <= wr_data[BIT_REQ];
                if (wr_data[BIT_ERR]) err_q <= 1'b0;
            end else if (locked) begin
                err_q <= 1'b1;
            end else begin
                tim_q[REG_AW'(wr_addr - 1'b1)] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data[BIT_REQ] = req_q;
            rd_data[BIT_RUN] = run_i;
            rd_data[BIT_ERR] = err_q;
        end else begin
            rd_data = tim_q[REG_AW'(rd_addr - 1'b1)];
        end
    end

    assign req_o = req_q;

    assign hcfg_o = '{
        act_m1:   lo_half(tim_q[A_HTOT-1]),
        tot_m1:   hi_half(tim_q[A_HTOT-1]),
        blk_s_m1: lo_half(tim_q[A_HBLK-1]),
        blk_e_m1: hi_half(tim_q[A_HBLK-1]),
        syn_s_m1: lo_half(tim_q[A_HSYN-1]),
        syn_e_m1: hi_half(tim_q[A_HSYN-1]),
        src_m1:   hi_half(tim_q[A_SRC-1])
    };

    assign vcfg_o = '{
        act_m1:   lo_half(tim_q[A_VTOT-1]),
        tot_m1:   hi_half(tim_q[A_VTOT-1]),
        blk_s_m1: lo_half(tim_q[A_VBLK-1]),
        blk_e_m1: hi_half(tim_q[A_VBLK-1]),
        syn_s_m1: lo_half(tim_q[A_VSYN-1]),
        syn_e_m1: hi_half(tim_q[A_VSYN-1]),
        src_m1:   lo_half(tim_q[A_SRC-1])
    };

    AST_BLOCKED_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
        (tim_wr && locked) |=> err_q);  // R9

    AST_BLOCKED_KEEPS_HTOT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_HTOT && locked) |=> (tim_q[A_HTOT-1] == $past(tim_q[A_HTOT-1])));  // R9

endmodule

// File: rtl/dtg_scan.sv
module dtg_scan
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  cnt_t htot_m1,
    input  cnt_t vtot_m1,
    output logic run_o,
    output cnt_t hcnt_o,
    output cnt_t vcnt_o
);

    logic run_q;
    cnt_t h_q;
    cnt_t v_q;
    logic line_end;
    logic frame_end;

    assign line_end  = (h_q == htot_m1);
    assign frame_end = line_end && (v_q == vtot_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            h_q   <= '0;
            v_q   <= '0;
        end else if (!run_q) begin
            run_q <= req_i;
            h_q   <= '0;
            v_q   <= '0;
        end else if (frame_end) begin
            h_q   <= '0;
            v_q   <= '0;
            run_q <= req_i;
        end else if (line_end) begin
            h_q <= '0;
            v_q <= v_q + 1'b1;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    assign run_o  = run_q;
    assign hcnt_o = h_q;
    assign vcnt_o = v_q;

    AST_START_AT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> (h_q == '0 && v_q == '0));  // R7

    AST_HWRAP: assert property (@(posedge clk) disable iff (rst)
        (run_q && h_q == htot_m1) |=> (h_q == '0));  // R2

    AST_STOP_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> ($past(h_q) == htot_m1 && $past(v_q) == vtot_m1));  // R8

endmodule

// File: rtl/dtg_axis_dec.sv
module dtg_axis_dec
    import dtg_pkg::*;
(
    input  cnt_t        cnt_i,
    input  axis_cfg_t   cfg_i,
    output axis_flags_t flags_o
);

    always_comb begin
        flags_o.act   = (cnt_i <= cfg_i.act_m1);
        flags_o.blank = in_span(cnt_i, cfg_i.blk_s_m1, cfg_i.blk_e_m1);
        flags_o.sync  = in_span(cnt_i, cfg_i.syn_s_m1, cfg_i.syn_e_m1);
        flags_o.src   = (cnt_i <= cfg_i.src_m1);
    end

endmodule

// File: rtl/dtg_top.sv
module dtg_top
    import dtg_pkg::*;
#(
    parameter bit SYNC_ACTIVE_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              hblank_o,
    output logic              vblank_o,
    output logic              de_o,
    output logic              src_hit_o,
    output logic [15:0]       pix_x_o,
    output logic [15:0]       pix_y_o
);

    localparam logic SYNC_IDLE = !SYNC_ACTIVE_HIGH;

    axis_cfg_t   hcfg;
    axis_cfg_t   vcfg;
    axis_cfg_t   cfg_ax [NUM_AX];
    cnt_t        cnt_ax [NUM_AX];
    axis_flags_t fl_ax  [NUM_AX];
    logic        req;
    logic        run;
    cnt_t        hcnt;
    cnt_t        vcnt;

    dtg_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .run_i   (run),
        .req_o   (req),
        .hcfg_o  (hcfg),
        .vcfg_o  (vcfg)
    );

    dtg_scan u_scan (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .htot_m1 (hcfg.tot_m1),
        .vtot_m1 (vcfg.tot_m1),
        .run_o   (run),
        .hcnt_o  (hcnt),
        .vcnt_o  (vcnt)
    );

    assign cfg_ax[0] = hcfg;
    assign cfg_ax[1] = vcfg;
    assign cnt_ax[0] = hcnt;
    assign cnt_ax[1] = vcnt;

    for (genvar a = 0; a < NUM_AX; a++) begin : g_axis
        dtg_axis_dec u_dec (
            .cnt_i   (cnt_ax[a]),
            .cfg_i   (cfg_ax[a]),
            .flags_o (fl_ax[a])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hsync_o   <= SYNC_IDLE;
            vsync_o   <= SYNC_IDLE;
            hblank_o  <= 1'b0;
            vblank_o  <= 1'b0;
            de_o      <= 1'b0;
            src_hit_o <= 1'b0;
            pix_x_o   <= '0;
            pix_y_o   <= '0;
        end else begin
            hsync_o   <= fl_ax[0].sync ^ SYNC_IDLE;
            vsync_o   <= fl_ax[1].sync ^ SYNC_IDLE;
            hblank_o  <= fl_ax[0].blank;
            vblank_o  <= fl_ax[1].blank;
            de_o      <= fl_ax[0].act && fl_ax[1].act;
            src_hit_o <= fl_ax[0].src && fl_ax[1].src;
            pix_x_o   <= hcnt;
            pix_y_o   <= vcnt;
        end
    end

    AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!de_o && !hblank_o && !vblank_o && !src_hit_o && pix_x_o == '0 && pix_y_o == '0));  // R10

    AST_COORD_FOLLOWS_COUNT: assert property (@(posedge clk) disable iff (rst)
        run |=> (pix_x_o == $past(hcnt) && pix_y_o == $past(vcnt)));  // R10

endmodule

// File: tb/dtg_top_tb_top.sv
module dtg_top_tb_top;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        hsync_o, vsync_o, hblank_o, vblank_o, de_o, src_hit_o;
    logic [15:0] pix_x_o, pix_y_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit          idle;
        logic [15:0] x, y;
        logic        hb, vb, hs, vs, de, src;
    } exp_t;

    exp_t q[$];
    bit   mon_on = 1'b0;

    int ha, hf, hp, ht, va, vf, vp, vt, sw, sh;

    always #(CLK_P/2) clk = ~clk;

    dtg_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .hblank_o(hblank_o), .vblank_o(vblank_o),
        .de_o(de_o), .src_hit_o(src_hit_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] pack(input int lo, input int hi);
        return {16'(hi - 1), 16'(lo - 1)};
    endfunction

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic program_axes();
        reg_write(3'd1, pack(ha, ht));
        reg_write(3'd2, pack(ha, ht));
        reg_write(3'd3, pack(ha + hf, ha + hf + hp));
        reg_write(3'd4, pack(va, vt));
        reg_write(3'd5, pack(va, vt));
        reg_write(3'd6, pack(va + vf, va + vf + vp));
        reg_write(3'd7, pack(sh, sw));
    endtask

    task automatic push_frames(input int nf, input int idle_n);
        for (int k = 0; k < nf * ht * vt; k++) begin
            exp_t e;
            int h = k % ht;
            int v = (k / ht) % vt;
            e.idle = 1'b0;
            e.x = 16'(h); e.y = 16'(v);
            e.hb = (h >= ha); e.vb = (v >= va);
            e.hs = (h >= ha + hf) && (h < ha + hf + hp);
            e.vs = (v >= va + vf) && (v < va + vf + vp);
            e.de = (h < ha) && (v < va);
            e.src = (h < sw) && (v < sh);
            q.push_back(e);
        end
        for (int k = 0; k < idle_n; k++) begin
            exp_t e;
            e.idle = 1'b1;
            e.x = '0; e.y = '0;
            e.hb = 0; e.vb = 0; e.hs = 0; e.vs = 0; e.de = 0; e.src = 0;
            q.push_back(e);
        end
    endtask

    // request written, status seen, stream armed (leaves driver at the negedge after E1)
    task automatic start_run(input int nf, input logic [31:0] ctl_extra);
        logic [31:0] d;
        reg_write(3'd0, 32'h8000_0000);
        reg_read(3'd0, d);
        chk(d == (32'h8000_0000 | ctl_extra), "R7 status before first frame", d, 32'h8000_0000 | ctl_extra);
        @(negedge clk);
        reg_read(3'd0, d);
        chk(d == (32'hC000_0000 | ctl_extra), "R7 status after request", d, 32'hC000_0000 | ctl_extra);
        push_frames(nf, 3);
        mon_on = 1'b1;
    endtask

    // monitor: pops one expected item per falling edge
    initial begin
        forever begin
            wait (mon_on);
            while (q.size() > 0) begin
                exp_t e;
                @(negedge clk);
                e = q.pop_front();
                if (e.idle) begin
                    chk({hsync_o, vsync_o, hblank_o, vblank_o, de_o, src_hit_o} == 6'b0 &&
                        pix_x_o == 0 && pix_y_o == 0, "R10 idle outputs",
                        {hsync_o, vsync_o, hblank_o, vblank_o, de_o, src_hit_o, pix_x_o[7:0], pix_y_o[7:0]}, 0);
                end else begin
                    chk(pix_x_o == e.x && pix_y_o == e.y, "R2 coordinates",
                        {pix_x_o, pix_y_o}, {e.x, e.y});
                    chk(hblank_o == e.hb && vblank_o == e.vb, "R3 blanking",
                        {hblank_o, vblank_o}, {e.hb, e.vb});
                    chk(hsync_o == e.hs && vsync_o == e.vs, "R4 sync",
                        {hsync_o, vsync_o}, {e.hs, e.vs});
                    chk(de_o == e.de, "R5 data enable", de_o, e.de);
                    chk(src_hit_o == e.src, "R6 source window", src_hit_o, e.src);
                end
            end
            mon_on = 1'b0;
        end
    end

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        reg_read(3'd0, d);
        chk(d == 0, "R7 control after reset", d, 0);
        chk({de_o, hblank_o, vblank_o, hsync_o, vsync_o, src_hit_o} == 0 && pix_x_o == 0 && pix_y_o == 0,
            "R10 outputs after reset", {de_o, hblank_o, vblank_o, pix_x_o}, 0);

        // pattern A
        ha = 8; hf = 2; hp = 3; ht = 16;
        va = 4; vf = 1; vp = 2; vt = 8;
        sw = 6; sh = 3;
        program_axes();
        reg_read(3'd3, d);
        chk(d == 32'h000C_0009, "R1 hsync word readback", d, 32'h000C_0009);
        reg_read(3'd7, d);
        chk(d == 32'h0005_0002, "R1 source word readback", d, 32'h0005_0002);
        repeat (4) @(negedge clk);
        chk(pix_x_o == 0 && de_o == 0, "R10 held while stopped", pix_x_o, 0);

        start_run(2, 32'h0);
        repeat (100) @(negedge clk);
        reg_write(3'd1, 32'hDEAD_BEEF);      // R9 blocked write mid-frame
        reg_read(3'd0, d);
        chk(d == 32'hE000_0000, "R9 error flag after blocked write", d, 32'hE000_0000);
        repeat (60) @(negedge clk);
        reg_write(3'd0, 32'h0000_0000);      // R8 clear request inside frame 2
        reg_read(3'd0, d);
        chk(d == 32'h6000_0000, "R8 still running after request cleared", d, 32'h6000_0000);
        wait (!mon_on);
        reg_read(3'd0, d);
        chk(d == 32'h2000_0000, "R8 stopped after frame end", d, 32'h2000_0000);
        reg_read(3'd1, d);
        chk(d == 32'h000F_0007, "R9 blocked word unchanged", d, 32'h000F_0007);

        reg_write(3'd0, 32'h2000_0000);      // R9 clear sticky error
        reg_read(3'd0, d);
        chk(d == 0, "R9 error cleared", d, 0);

        // pattern B
        ha = 4; hf = 1; hp = 2; ht = 8;
        va = 2; vf = 1; vp = 1; vt = 4;
        sw = 4; sh = 2;
        program_axes();
        reg_read(3'd4, d);
        chk(d == 32'h0003_0001, "R1 vtotal word readback", d, 32'h0003_0001);
        reg_read(3'd0, d);
        chk(d == 0, "R9 no error for writes while stopped", d, 0);
        start_run(1, 32'h0);
        reg_write(3'd0, 32'h0000_0000);      // R8 request dropped at frame start
        wait (!mon_on);
        reg_read(3'd0, d);
        chk(d == 0, "R8 single frame then stop", d, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule